// File: doc/BRIEF.md
# Signed Bit-Address Stepper

This block moves a bit-granular memory address forward or backward by a signed
bit count. The address has three parts: a segment byte on top, a 16-bit word
field, and a 4-bit bit-within-word field. The step is a signed 16-bit number of
bits. Its low nibble goes into the bit field. Its upper bits, shifted down by
four places with the sign filled in, go into the word field. A carry out of the
bit nibble adds one more word. The carry or borrow out of the word field turns
into a segment correction of +1, 0 or -1, and that correction is applied to the
segment byte.

There are two identical channels, one for a source address and one for a
destination address. Each has its own start strobe, operands, results and done
pulse, so a block-transfer engine can step both pointers at the same time. A
start is accepted only while its channel is idle. The results appear together
with a one-cycle done pulse after a latency that depends on the data. They then
hold until that channel finishes its next operation.

Top module: `bit_addr_stepper`

## Requirements
- R1: The new bit field equals (bit + step[3:0]) mod 16. A carry out of that 4-bit add counts as one extra word.
- R2: The new word field equals (word + (step arithmetically shifted right by 4) + nibble carry) mod 65536.
- R3: The segment correction output uses the code 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1; 2'b10 never appears. For a step with bit 15 clear, a carry out of the word add gives 2'b01 and no carry gives 2'b00.
- R4: For a step with bit 15 set, the absence of a carry out of the word add (a borrow) gives 2'b11, and a carry gives 2'b00.
- R5: The new segment byte equals the input segment plus the correction, modulo 256. Wrapping past 255 or below 0 raises no indication.
- R6: Counting the rising edge that samples the start as edge 1, done is high after edge 2. One more edge is added when the step is negative, and one more again when the correction is nonzero, so the latency is 2 to 4 edges.
- R7: Done is high for exactly one cycle per accepted operation. The result outputs change only on the edge that raises done and otherwise keep their values.
- R8: A start that arrives while the channel is busy, including the edge on which done is raised, is ignored. The result is that of the accepted operation.
- R9: The source and destination channels never affect each other's timing or results, even when both start on the same edge.
- R10: While reset is low, every result output and both done outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_start_i | input | 1 | Source channel start strobe |
| src_seg_i | input | 8 | Source segment byte |
| src_word_i | input | 16 | Source word field |
| src_bit_i | input | 4 | Source bit-in-word field |
| src_inc_i | input | 16 | Source signed bit step |
| src_bit_o | output | 4 | Source updated bit field |
| src_word_o | output | 16 | Source updated word field |
| src_mod_o | output | 2 | Source segment correction code |
| src_seg_o | output | 8 | Source updated segment byte |
| src_done_o | output | 1 | Source completion pulse |
| dst_start_i | input | 1 | Destination channel start strobe |
| dst_seg_i | input | 8 | Destination segment byte |
| dst_word_i | input | 16 | Destination word field |
| dst_bit_i | input | 4 | Destination bit-in-word field |
| dst_inc_i | input | 16 | Destination signed bit step |
| dst_bit_o | output | 4 | Destination updated bit field |
| dst_word_o | output | 16 | Destination updated word field |
| dst_mod_o | output | 2 | Destination segment correction code |
| dst_seg_o | output | 8 | Destination updated segment byte |
| dst_done_o | output | 1 | Destination completion pulse |

## Verification
The directed cases are chosen so that each one takes a different carry path:

| Case | What it exercises |
|---|---|
| Small positive step, no carry | Base 2-edge latency |
| Step that only carries out of the bit nibble | Nibble carry (R1) |
| Step that carries out of the word field | +1 correction and the extra latency edge |
| Negative steps with a borrow and without one | Negative delay, and -1 correction against 0 |
| Steps at segment 0xFF and 0x00 | Silent segment wrap |

Back-to-back strobes check that starts arriving while busy are ignored. Strobes
on both channels at once check that the channels stay independent. A long run
of random strobes and operands on both channels is then compared, cycle by
cycle, against a model that does plain integer arithmetic on the full 28-bit
address.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {
    SEG_HOLD = 2'b00,
    SEG_UP   = 2'b01,
    SEG_DOWN = 2'b11
  } seg_mod_e;
endpackage

// File: rtl/bas_calc.sv
module bas_calc
  import bas_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int WORD_W = 16,
  parameter int BIT_W  = 4
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [WORD_W-1:0] inc_i,
  output logic [BIT_W-1:0]  bit_o,
  output logic [WORD_W-1:0] word_o,
  output seg_mod_e          mod_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic              neg_o
);
  logic [BIT_W:0]    nib_sum;
  logic [WORD_W-1:0] word_step;
  logic [WORD_W:0]   word_sum;
  logic              word_co;

  assign neg_o     = inc_i[WORD_W-1];
  assign nib_sum   = {1'b0, bit_i} + {1'b0, inc_i[BIT_W-1:0]};
  // drop the bit nibble, move word part down, sign-fill the vacated top
  assign word_step = {{BIT_W{neg_o}}, inc_i[WORD_W-1:BIT_W]};
  assign word_sum  = {1'b0, word_i} + {1'b0, word_step} + {{WORD_W{1'b0}}, nib_sum[BIT_W]};
  assign word_co   = word_sum[WORD_W];

  assign bit_o  = nib_sum[BIT_W-1:0];
  assign word_o = word_sum[WORD_W-1:0];

  always_comb begin
    if (neg_o) mod_o = word_co ? SEG_HOLD : SEG_DOWN;
    else       mod_o = word_co ? SEG_UP   : SEG_HOLD;
  end

  always_comb begin
    unique case (mod_o)
      SEG_UP:   seg_o = seg_i + SEG_W'(1);
      SEG_DOWN: seg_o = seg_i - SEG_W'(1);
      default:  seg_o = seg_i;
    endcase
  end
endmodule

// File: rtl/bas_seq.sv
module bas_seq #(
  parameter int BASE_LAT  = 2,
  parameter int NEG_EXTRA = 1,
  parameter int SEG_EXTRA = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic neg_i,
  input  logic seg_fix_i,
  output logic accept_o,
  output logic fire_o,
  output logic done_o
);
  localparam int MAX_LAT = BASE_LAT + NEG_EXTRA + SEG_EXTRA;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  logic             busy_q;
  logic [LAT_W-1:0] cnt_q, load;

  always_comb begin
    load = LAT_W'(BASE_LAT - 1);
    if (neg_i)     load = load + LAT_W'(NEG_EXTRA);
    if (seg_fix_i) load = load + LAT_W'(SEG_EXTRA);
  end

  assign accept_o = start_i && !busy_q;
  assign fire_o   = busy_q && (cnt_q == LAT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= fire_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= load;
      end else if (fire_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q - LAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bas_chan.sv
module bas_chan
  import bas_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int WORD_W = 16,
  parameter int BIT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [WORD_W-1:0] inc_i,
  output logic [BIT_W-1:0]  bit_o,
  output logic [WORD_W-1:0] word_o,
  output logic [1:0]        mod_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic              done_o
);
  logic [BIT_W-1:0]  c_bit, p_bit;
  logic [WORD_W-1:0] c_word, p_word;
  logic [SEG_W-1:0]  c_seg, p_seg;
  seg_mod_e          c_mod, p_mod;
  logic              c_neg, accept, fire;

  bas_calc #(.SEG_W(SEG_W), .WORD_W(WORD_W), .BIT_W(BIT_W)) u_calc (
    .seg_i (seg_i),  .word_i(word_i), .bit_i(bit_i), .inc_i(inc_i),
    .bit_o (c_bit),  .word_o(c_word), .mod_o(c_mod), .seg_o(c_seg),
    .neg_o (c_neg)
  );

  bas_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .neg_i    (c_neg),
    .seg_fix_i(c_mod != SEG_HOLD),
    .accept_o (accept),
    .fire_o   (fire),
    .done_o   (done_o)
  );

  // operands are captured on accept; results publish with done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_bit  <= '0; p_word <= '0; p_seg <= '0; p_mod <= SEG_HOLD;
      bit_o  <= '0; word_o <= '0; seg_o <= '0; mod_o <= 2'b00;
    end else begin
      if (accept) begin
        p_bit <= c_bit; p_word <= c_word; p_seg <= c_seg; p_mod <= c_mod;
      end
      if (fire) begin
        bit_o <= p_bit; word_o <= p_word; seg_o <= p_seg; mod_o <= p_mod;
      end
    end
  end
endmodule

// File: rtl/bit_addr_stepper.sv
module bit_addr_stepper #(
  parameter int SEG_W  = 8,
  parameter int WORD_W = 16,
  parameter int BIT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_start_i,
  input  logic [SEG_W-1:0]  src_seg_i,
  input  logic [WORD_W-1:0] src_word_i,
  input  logic [BIT_W-1:0]  src_bit_i,
  input  logic [WORD_W-1:0] src_inc_i,
  output logic [BIT_W-1:0]  src_bit_o,
  output logic [WORD_W-1:0] src_word_o,
  output logic [1:0]        src_mod_o,
  output logic [SEG_W-1:0]  src_seg_o,
  output logic              src_done_o,
  input  logic              dst_start_i,
  input  logic [SEG_W-1:0]  dst_seg_i,
  input  logic [WORD_W-1:0] dst_word_i,
  input  logic [BIT_W-1:0]  dst_bit_i,
  input  logic [WORD_W-1:0] dst_inc_i,
  output logic [BIT_W-1:0]  dst_bit_o,
  output logic [WORD_W-1:0] dst_word_o,
  output logic [1:0]        dst_mod_o,
  output logic [SEG_W-1:0]  dst_seg_o,
  output logic              dst_done_o
);
  bas_chan #(.SEG_W(SEG_W), .WORD_W(WORD_W), .BIT_W(BIT_W)) u_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(src_start_i),
    .seg_i(src_seg_i), .word_i(src_word_i), .bit_i(src_bit_i), .inc_i(src_inc_i),
    .bit_o(src_bit_o), .word_o(src_word_o), .mod_o(src_mod_o), .seg_o(src_seg_o),
    .done_o(src_done_o)
  );

  bas_chan #(.SEG_W(SEG_W), .WORD_W(WORD_W), .BIT_W(BIT_W)) u_dst (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(dst_start_i),
    .seg_i(dst_seg_i), .word_i(dst_word_i), .bit_i(dst_bit_i), .inc_i(dst_inc_i),
    .bit_o(dst_bit_o), .word_o(dst_word_o), .mod_o(dst_mod_o), .seg_o(dst_seg_o),
    .done_o(dst_done_o)
  );
endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
  parameter int SEG_W   = 8,
  parameter int WORD_W  = 16,
  parameter int BIT_W   = 4,
  parameter int MAX_LAT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_i,
  input logic [BIT_W-1:0]  bit_i,
  input logic [WORD_W-1:0] word_i,
  input logic [1:0]        mod_i,
  input logic [SEG_W-1:0]  seg_i
);
  logic       pend_q;
  logic [3:0] wait_q;

  // independent view of the channel: pending from accepted start to done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wait_q <= '0;
    end else if (start_i && (!pend_q || done_i)) begin
      pend_q <= 1'b1;
      wait_q <= '0;
    end else if (done_i) begin
      pend_q <= 1'b0;
    end else if (pend_q && wait_q != 4'hF) begin
      wait_q <= wait_q + 4'd1;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable({bit_i, word_i, mod_i, seg_i}));

  p_mod_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_i != 2'b10);

  p_done_after_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> pend_q);

  p_latency_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (wait_q < 4'(MAX_LAT)));
endmodule

bind bit_addr_stepper bas_chk #(.SEG_W(SEG_W), .WORD_W(WORD_W), .BIT_W(BIT_W)) u_chk_src (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(src_start_i), .done_i(src_done_o),
  .bit_i(src_bit_o), .word_i(src_word_o), .mod_i(src_mod_o), .seg_i(src_seg_o)
);

bind bit_addr_stepper bas_chk #(.SEG_W(SEG_W), .WORD_W(WORD_W), .BIT_W(BIT_W)) u_chk_dst (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(dst_start_i), .done_i(dst_done_o),
  .bit_i(dst_bit_o), .word_i(dst_word_o), .mod_i(dst_mod_o), .seg_i(dst_seg_o)
);

// File: tb/tb_bit_addr_stepper.sv
module tb_bit_addr_stepper;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start_in [2];
  logic [7:0]  seg_in   [2];
  logic [15:0] word_in  [2];
  logic [3:0]  bit_in   [2];
  logic [15:0] inc_in   [2];
  logic [3:0]  bit_out  [2];
  logic [15:0] word_out [2];
  logic [1:0]  mod_out  [2];
  logic [7:0]  seg_out  [2];
  logic        done_out [2];

  bit_addr_stepper dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .src_start_i(start_in[0]), .src_seg_i(seg_in[0]), .src_word_i(word_in[0]),
    .src_bit_i(bit_in[0]), .src_inc_i(inc_in[0]),
    .src_bit_o(bit_out[0]), .src_word_o(word_out[0]), .src_mod_o(mod_out[0]),
    .src_seg_o(seg_out[0]), .src_done_o(done_out[0]),
    .dst_start_i(start_in[1]), .dst_seg_i(seg_in[1]), .dst_word_i(word_in[1]),
    .dst_bit_i(bit_in[1]), .dst_inc_i(inc_in[1]),
    .dst_bit_o(bit_out[1]), .dst_word_o(word_out[1]), .dst_mod_o(mod_out[1]),
    .dst_seg_o(seg_out[1]), .dst_done_o(done_out[1])
  );

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R10";
  bit finished = 0;

  // behavioural model: whole address as one 28-bit integer
  int m_busy[2], m_cnt[2], m_done[2];
  int m_bit[2], m_word[2], m_seg[2], m_mod[2];
  int q_bit[2], q_word[2], q_seg[2], q_mod[2];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        m_busy[c] = 0; m_cnt[c] = 0; m_done[c] = 0;
        m_bit[c] = 0; m_word[c] = 0; m_seg[c] = 0; m_mod[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        m_done[c] = 0;
        if (m_busy[c] != 0) begin
          if (m_cnt[c] == 1) begin
            m_bit[c] = q_bit[c]; m_word[c] = q_word[c];
            m_seg[c] = q_seg[c]; m_mod[c] = q_mod[c];
            m_done[c] = 1; m_busy[c] = 0;
          end else m_cnt[c]--;
        end else if (start_in[c]) begin
          longint a, s;
          int d, diff;
          d = $signed(inc_in[c]);
          a = longint'(seg_in[c]) * 1048576 + longint'(word_in[c]) * 16 + longint'(bit_in[c]);
          s = (a + d + 268435456) % 268435456;
          q_bit[c]  = int'(s % 16);
          q_word[c] = int'((s / 16) % 65536);
          q_seg[c]  = int'(s / 1048576);
          diff = (q_seg[c] - int'(seg_in[c]) + 256) % 256;
          q_mod[c] = (diff == 1) ? 1 : (diff == 255) ? -1 : 0;
          m_busy[c] = 1;
          m_cnt[c] = 1 + ((d < 0) ? 1 : 0) + ((q_mod[c] != 0) ? 1 : 0);
        end
      end
    end
  end

  task automatic chk(string req, int c, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] ch%0d actual=%0h expected=%0h", req, phase, c, act, exp);
    end
  endtask

  function automatic int mod_code(int m);
    return (m == 1) ? 1 : (m == -1) ? 3 : 0;
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        chk("R6 done", c, int'(done_out[c]), m_done[c]);
        chk("R1 bit", c, int'(bit_out[c]), m_bit[c]);
        chk("R2 word", c, int'(word_out[c]), m_word[c]);
        chk((m_mod[c] < 0) ? "R4 mod" : "R3 mod", c, int'(mod_out[c]), mod_code(m_mod[c]));
        chk("R5 seg", c, int'(seg_out[c]), m_seg[c]);
      end
    end
  end

  task automatic drive(int c, logic s, logic [7:0] sg, logic [15:0] w, logic [3:0] b, logic [15:0] i);
    start_in[c] = s; seg_in[c] = sg; word_in[c] = w; bit_in[c] = b; inc_in[c] = i;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy[0] != 0 || m_busy[1] != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic op(int c, logic [7:0] sg, logic [15:0] w, logic [3:0] b, logic [15:0] i);
    @(negedge clk);
    drive(c, 1'b1, sg, w, b, i);
    @(negedge clk);
    start_in[c] = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog [%s] run did not complete", phase);
    finish_run();
  end

  initial begin
    for (int c = 0; c < 2; c++) drive(c, 1'b0, 8'h00, 16'h0000, 4'h0, 16'h0000);
    // R10: outputs zero in reset
    repeat (3) @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R10 bit", c, int'(bit_out[c]), 0);
      chk("R10 word", c, int'(word_out[c]), 0);
      chk("R10 mod", c, int'(mod_out[c]), 0);
      chk("R10 seg", c, int'(seg_out[c]), 0);
      chk("R10 done", c, int'(done_out[c]), 0);
    end
    rst_ni = 1'b1;

    phase = "R1"; op(0, 8'h05, 16'h1000, 4'h3, 16'h0005);     // plain, 2 edges
    op(0, 8'h05, 16'h1000, 4'hE, 16'h0003);                   // nibble carry
    op(1, 8'h21, 16'h00FF, 4'h8, 16'h0128);
    phase = "R3"; op(0, 8'h10, 16'hFFFF, 4'hF, 16'h0001);     // +1 segment
    op(1, 8'h10, 16'hFFF0, 4'h0, 16'h0200);
    phase = "R4"; op(0, 8'h10, 16'h0000, 4'h0, 16'hFFFF);     // borrow -> -1
    op(0, 8'h10, 16'h0005, 4'h2, 16'hFFF0);                   // negative, no borrow
    op(1, 8'h33, 16'h0001, 4'h4, 16'h8000);
    phase = "R5"; op(0, 8'hFF, 16'hFFFF, 4'hF, 16'h0001);     // wrap up
    op(1, 8'h00, 16'h0000, 4'h0, 16'hFFF8);                   // wrap down
    phase = "R6"; op(1, 8'h44, 16'h1234, 4'h5, 16'h7FFF);

    // R8: start held and operands changed while busy
    phase = "R8";
    @(negedge clk); drive(0, 1'b1, 8'h01, 16'h0010, 4'h1, 16'h0011);
    @(negedge clk); drive(0, 1'b1, 8'h99, 16'hFFFF, 4'hF, 16'hFFFF);
    repeat (4) @(negedge clk);
    start_in[0] = 1'b0;
    wait_idle();

    // R9: both channels together, different latencies
    phase = "R9";
    @(negedge clk);
    drive(0, 1'b1, 8'h7F, 16'hFFFF, 4'hC, 16'h0004);
    drive(1, 1'b1, 8'h02, 16'h4000, 4'h1, 16'h0010);
    @(negedge clk); start_in[0] = 1'b0; start_in[1] = 1'b0;
    wait_idle();

    // R7 and mixed traffic on both channels
    phase = "R7";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        logic [15:0] i;
        i = ($urandom % 2 == 0) ? 16'($urandom) : 16'($signed(6'($urandom)));
        drive(c, ($urandom % 3) == 0, 8'($urandom), 16'($urandom), 4'($urandom), i);
      end
    end
    @(negedge clk); start_in[0] = 1'b0; start_in[1] = 1'b0;
    wait_idle();
    finish_run();
  end
endmodule